// File: doc/BRIEF.md
# Video Memory Cycle-Type Decoder

This block is the control front end of a dual-port video memory. The memory strobes reach it as active-low inputs. The two column-strobe halves are merged into a single column strobe, which counts as low when either half is low. All strobe, address and data pins then pass through one shared register chain clocked by a system clock, so they stay aligned with each other. Each strobe falling edge becomes a one-clock pulse. The system clock must run at least four times faster than the strobe rate.

At the row-strobe fall the block records the levels of the column strobe, transfer strobe, write enable and function select, together with the row address and the data pins. Cycles started with the column strobe low are refresh cycles. Cycles started with the transfer strobe low are register-transfer reads. Both kinds are classified at once. Any other cycle is a write or a register load, and it is classified at the first column-strobe fall, where function select is sampled a second time. Data is captured at the later of the column-strobe fall and the write-enable fall.

The block keeps two sticky mode flags: persistent write-per-bit and stop-point. It also holds a stop-point code, a write-mask register and a colour register. After reset, a power-up flag stays raised until the first stop-point refresh.

The controller has four states:
- `ST_IDLE`: the row strobe is high.
- `ST_ROW`: a write or load is waiting for the column strobe.
- `ST_WAIT_WE`: a late write is waiting for write enable to fall.
- `ST_HOLD`: the cycle is decoded and the block waits for the row strobe to rise.

The transitions are:
- Row fall leads from `ST_IDLE` to `ST_HOLD` for a refresh or transfer.
- Row fall leads from `ST_IDLE` to `ST_ROW` otherwise.
- Column fall leads from `ST_ROW` to `ST_HOLD` if write enable is already low.
- Column fall leads from `ST_ROW` to `ST_WAIT_WE` if write enable is still high.
- Write-enable fall leads from `ST_WAIT_WE` to `ST_HOLD`.
- A high row strobe returns every other state to `ST_IDLE`.

Top module: `vram_cycle_decoder`

## Requirements
- R1: After reset, `persist_wpb`, `stop_en`, `cyc_valid`, `data_valid` and `illegal` are 0, and `powerup_req` is 1.
- R2: Column strobe low at row fall means a refresh cycle, and either half being low counts as low. The type is then chosen by write enable and function select at row fall: WE low with DSF low gives RSVD (1), WE low with DSF high gives STOP (2), WE high with DSF low gives RESET (3), and WE high with DSF high gives KEEP (4).
- R3: Column strobe high and transfer strobe low at row fall give XFER_FULL (5) when DSF is low and XFER_SPLIT (6) when DSF is high, provided write enable is high. With write enable low the type is RSVD (1).
- R4: Column and transfer strobes both high at row fall lead to classification at the first column fall, with DSF sampled again there (written dc below). WE high with DSF low at row fall gives WRITE (7) when dc=0 and BLOCK_WRITE (8) when dc=1. WE high with DSF high gives LOAD_MASK (11) when dc=0 and LOAD_COLOR (12) when dc=1. WE low gives WRITE_MASKED (9) when dc=0 and BLOCK_MASKED (10) when dc=1. Every cycle produces exactly one `cyc_valid` pulse carrying its type on `cyc_type`.
- R5: A LOAD_MASK cycle sets `persist_wpb` and loads its captured data into `mask_reg`. A LOAD_COLOR cycle loads its captured data into `color`.
- R6: A RESET refresh clears `persist_wpb` and `stop_en`. A KEEP refresh changes neither flag. `persist_wpb` falls only on a RESET refresh.
- R7: A STOP refresh sets `stop_en`, takes `stop_code` from address bits 7..4 at row fall (the other bits are ignored), and clears `powerup_req`.
- R8: In write and load cycles, `data` takes the data pins at the later of the first column fall and the write-enable fall, with one `data_valid` pulse per cycle. Refresh and transfer cycles give no `data_valid`.
- R9: `row_addr` takes the address at row fall. `col_addr` takes the address at the first column fall.
- R10: `wr_mask` is all ones for WRITE and BLOCK_WRITE. For the masked types it is `mask_reg` when `persist_wpb` is set or DSF was high at row fall, and otherwise the data pins at row fall.
- R11: An RSVD cycle pulses `illegal` for one clock together with `cyc_valid`, and it changes no mode flag, `stop_code`, `mask_reg` or `color`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower column strobe, active low |
| casu_n | input | 1 | Upper column strobe, active low |
| trg_n | input | 1 | Transfer/output strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| addr | input | ADDR_W | Multiplexed address |
| dq | input | DQ_W | Data pins |
| cyc_valid | output | 1 | One-clock pulse when a cycle is classified |
| cyc_type | output | 4 | Cycle type code (R2 to R4) |
| illegal | output | 1 | One-clock pulse on a reserved cycle |
| row_addr | output | ADDR_W | Address at row fall |
| col_addr | output | ADDR_W | Address at first column fall |
| wr_mask | output | DQ_W | Effective bit mask of the current write |
| data_valid | output | 1 | One-clock pulse on data capture |
| data | output | DQ_W | Captured data |
| mask_reg | output | DQ_W | Write-mask register |
| color | output | DQ_W | Colour register |
| persist_wpb | output | 1 | Persistent write-per-bit flag |
| stop_en | output | 1 | Stop-point flag |
| stop_code | output | 4 | Stop-point code |
| powerup_req | output | 1 | High until the first STOP refresh |

## Verification
A stale row-fall sample or a wrong state shows up within the same memory cycle. It appears as a wrong `cyc_type`, a missing or doubled `cyc_valid` or `data_valid` pulse, or data taken at the column edge instead of the write edge. A wrong sticky flag may hide for many cycles. It becomes visible at the next masked write, where `wr_mask` picks the wrong source, or on the flag ports after the next refresh. The bench therefore checks the flags and registers after every memory cycle, over two full sweeps of all strobe combinations.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

    typedef enum logic [3:0] {
        CYC_NONE         = 4'd0,
        CYC_RSVD         = 4'd1,
        CYC_REF_STOP     = 4'd2,
        CYC_REF_RESET    = 4'd3,
        CYC_REF_KEEP     = 4'd4,
        CYC_XFER_FULL    = 4'd5,
        CYC_XFER_SPLIT   = 4'd6,
        CYC_WRITE        = 4'd7,
        CYC_BLOCK_WRITE  = 4'd8,
        CYC_WRITE_MASKED = 4'd9,
        CYC_BLOCK_MASKED = 4'd10,
        CYC_LOAD_MASK    = 4'd11,
        CYC_LOAD_COLOR   = 4'd12
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROW,
        ST_WAIT_WE,
        ST_HOLD
    } vdc_state_e;

endpackage

// File: rtl/vdc_sync.sv
module vdc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else if (g == 0) pipe[g] <= d;
            else pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/vdc_edge.sv
module vdc_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else prev <= lvl;
    end

    assign fall = prev & ~lvl;
endmodule

// File: rtl/vdc_ctrl.sv
module vdc_ctrl
    import vdc_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DQ_W     = 16,
    parameter int STOP_LSB = 4,
    parameter int STOP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_fall,
    input  logic              cas_fall,
    input  logic              we_fall,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              trg_n,
    input  logic              we_n,
    input  logic              dsf,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq,
    output logic              cyc_valid,
    output cyc_e              cyc_type,
    output logic              illegal,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic [DQ_W-1:0]   wr_mask,
    output logic              data_valid,
    output logic [DQ_W-1:0]   data,
    output logic [DQ_W-1:0]   mask_reg,
    output logic [DQ_W-1:0]   color,
    output logic              persist_wpb,
    output logic              stop_en,
    output logic [STOP_W-1:0] stop_code,
    output logic              powerup_req
);
    vdc_state_e state, nxt;
    logic            ras_we_n, ras_dsf;
    logic [DQ_W-1:0] ras_dq;
    cyc_e            cur_type, late_type, cap_type;
    logic            cap_now;

    // Classification of write/load cycles at the first column fall.
    always_comb begin
        unique case ({ras_we_n, ras_dsf})
            2'b10:   late_type = dsf ? CYC_BLOCK_WRITE  : CYC_WRITE;
            2'b11:   late_type = dsf ? CYC_LOAD_COLOR   : CYC_LOAD_MASK;
            default: late_type = dsf ? CYC_BLOCK_MASKED : CYC_WRITE_MASKED;
        endcase
    end

    assign cap_type = (state == ST_ROW) ? late_type : cur_type;
    assign cap_now  = ((state == ST_ROW) && !ras_n && cas_fall && !we_n)
                   || ((state == ST_WAIT_WE) && !ras_n && we_fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (ras_fall) nxt = (!cas_n || !trg_n) ? ST_HOLD : ST_ROW;
            ST_ROW:     if (ras_n) nxt = ST_IDLE;
                        else if (cas_fall) nxt = we_n ? ST_WAIT_WE : ST_HOLD;
            ST_WAIT_WE: if (ras_n) nxt = ST_IDLE;
                        else if (we_fall) nxt = ST_HOLD;
            ST_HOLD:    if (ras_n) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_valid   <= 1'b0;
            cyc_type    <= CYC_NONE;
            cur_type    <= CYC_NONE;
            illegal     <= 1'b0;
            row_addr    <= '0;
            col_addr    <= '0;
            wr_mask     <= '1;
            data_valid  <= 1'b0;
            data        <= '0;
            mask_reg    <= '0;
            color       <= '0;
            persist_wpb <= 1'b0;
            stop_en     <= 1'b0;
            stop_code   <= '0;
            powerup_req <= 1'b1;
            ras_we_n    <= 1'b1;
            ras_dsf     <= 1'b0;
            ras_dq      <= '0;
        end else begin
            cyc_valid  <= 1'b0;
            illegal    <= 1'b0;
            data_valid <= 1'b0;
            if (state == ST_IDLE && ras_fall) begin
                row_addr <= addr;
                ras_we_n <= we_n;
                ras_dsf  <= dsf;
                ras_dq   <= dq;
                if (!cas_n) begin
                    cyc_valid <= 1'b1;
                    unique case ({we_n, dsf})
                        2'b00: begin
                            cyc_type <= CYC_RSVD;
                            illegal  <= 1'b1;
                        end
                        2'b01: begin
                            cyc_type    <= CYC_REF_STOP;
                            stop_en     <= 1'b1;
                            stop_code   <= addr[STOP_LSB +: STOP_W];
                            powerup_req <= 1'b0;
                        end
                        2'b10: begin
                            cyc_type    <= CYC_REF_RESET;
                            persist_wpb <= 1'b0;
                            stop_en     <= 1'b0;
                        end
                        default: cyc_type <= CYC_REF_KEEP;
                    endcase
                end else if (!trg_n) begin
                    cyc_valid <= 1'b1;
                    illegal   <= !we_n;
                    cyc_type  <= !we_n ? CYC_RSVD
                               : (dsf ? CYC_XFER_SPLIT : CYC_XFER_FULL);
                end
            end
            if (state == ST_ROW && !ras_n && cas_fall) begin
                col_addr  <= addr;
                cyc_valid <= 1'b1;
                cyc_type  <= late_type;
                cur_type  <= late_type;
                if (late_type == CYC_LOAD_MASK) persist_wpb <= 1'b1;
                if (late_type == CYC_WRITE_MASKED || late_type == CYC_BLOCK_MASKED)
                    wr_mask <= (persist_wpb || ras_dsf) ? mask_reg : ras_dq;
                else
                    wr_mask <= '1;
            end
            if (cap_now) begin
                data       <= dq;
                data_valid <= 1'b1;
                if (cap_type == CYC_LOAD_MASK)  mask_reg <= dq;
                if (cap_type == CYC_LOAD_COLOR) color    <= dq;
            end
        end
    end
endmodule

// File: rtl/vram_cycle_decoder.sv
module vram_cycle_decoder
    import vdc_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DQ_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int STOP_LSB    = 4,
    parameter int STOP_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              casl_n,
    input  logic              casu_n,
    input  logic              trg_n,
    input  logic              we_n,
    input  logic              dsf,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq,
    output logic              cyc_valid,
    output logic [3:0]        cyc_type,
    output logic              illegal,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic [DQ_W-1:0]   wr_mask,
    output logic              data_valid,
    output logic [DQ_W-1:0]   data,
    output logic [DQ_W-1:0]   mask_reg,
    output logic [DQ_W-1:0]   color,
    output logic              persist_wpb,
    output logic              stop_en,
    output logic [STOP_W-1:0] stop_code,
    output logic              powerup_req
);
    localparam int BUS_W = 5 + ADDR_W + DQ_W;
    localparam logic [BUS_W-1:0] BUS_IDLE = {4'b1111, {(BUS_W-4){1'b0}}};

    logic [BUS_W-1:0] bus_raw, bus_s;
    logic s_ras_n, s_cas_n, s_trg_n, s_we_n, s_dsf;
    logic [ADDR_W-1:0] s_addr;
    logic [DQ_W-1:0]   s_dq;
    logic [2:0] falls;
    cyc_e type_e;

    assign bus_raw = {ras_n, casl_n & casu_n, trg_n, we_n, dsf, addr, dq};

    vdc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
    );

    assign {s_ras_n, s_cas_n, s_trg_n, s_we_n, s_dsf, s_addr, s_dq} = bus_s;

    vdc_edge #(.N(3)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl({s_we_n, s_cas_n, s_ras_n}), .fall(falls)
    );

    vdc_ctrl #(
        .ADDR_W(ADDR_W), .DQ_W(DQ_W), .STOP_LSB(STOP_LSB), .STOP_W(STOP_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ras_fall(falls[0]), .cas_fall(falls[1]), .we_fall(falls[2]),
        .ras_n(s_ras_n), .cas_n(s_cas_n), .trg_n(s_trg_n), .we_n(s_we_n),
        .dsf(s_dsf), .addr(s_addr), .dq(s_dq),
        .cyc_valid(cyc_valid), .cyc_type(type_e), .illegal(illegal),
        .row_addr(row_addr), .col_addr(col_addr), .wr_mask(wr_mask),
        .data_valid(data_valid), .data(data), .mask_reg(mask_reg),
        .color(color), .persist_wpb(persist_wpb), .stop_en(stop_en),
        .stop_code(stop_code), .powerup_req(powerup_req)
    );

    assign cyc_type = type_e;
endmodule

// File: rtl/vdc_checker.sv
module vdc_checker
    import vdc_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cyc_valid,
    input logic [3:0]      cyc_type,
    input logic            illegal,
    input logic [DQ_W-1:0] wr_mask,
    input logic            data_valid,
    input logic            persist_wpb,
    input logic            stop_en,
    input logic            powerup_req
);
    a_r11_illegal_is_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (cyc_valid && cyc_type == 4'(CYC_RSVD)));

    a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(persist_wpb) && $stable(stop_en) && $stable(powerup_req)));

    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 4'(CYC_REF_RESET)) |-> (!persist_wpb && !stop_en));

    a_r6_persist_falls_only_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(persist_wpb) |-> (cyc_valid && cyc_type == 4'(CYC_REF_RESET)));

    a_r5_load_mask_sets_persist: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 4'(CYC_LOAD_MASK)) |-> persist_wpb);

    a_r7_stop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 4'(CYC_REF_STOP)) |-> (stop_en && !powerup_req));

    a_r8_data_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    a_r10_unmasked_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 4'(CYC_WRITE)) |-> (wr_mask == '1));
endmodule

bind vram_cycle_decoder vdc_checker #(.DQ_W(DQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .illegal(illegal), .wr_mask(wr_mask), .data_valid(data_valid),
    .persist_wpb(persist_wpb), .stop_en(stop_en), .powerup_req(powerup_req)
);

// File: tb/vram_cycle_decoder_tb.sv
module vram_cycle_decoder_tb;
    import vdc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, casl_n = 1'b1, casu_n = 1'b1, trg_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
    logic [8:0]  addr = '0;
    logic [15:0] dq = '0;
    logic        cyc_valid, illegal, data_valid, persist_wpb, stop_en, powerup_req;
    logic [3:0]  cyc_type, stop_code;
    logic [8:0]  row_addr, col_addr;
    logic [15:0] wr_mask, data, mask_reg, color;

    int tests = 0, fails = 0;
    int n_valid = 0, n_data = 0, n_ill = 0;
    logic [3:0]  seen_type;
    logic [15:0] seen_data;

    bit          m_persist, m_stop, m_pwr;
    logic [3:0]  m_code;
    logic [15:0] m_mask, m_color;

    always #5 clk = ~clk;

    vram_cycle_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .casu_n(casu_n),
        .trg_n(trg_n), .we_n(we_n), .dsf(dsf), .addr(addr), .dq(dq),
        .cyc_valid(cyc_valid), .cyc_type(cyc_type), .illegal(illegal),
        .row_addr(row_addr), .col_addr(col_addr), .wr_mask(wr_mask),
        .data_valid(data_valid), .data(data), .mask_reg(mask_reg), .color(color),
        .persist_wpb(persist_wpb), .stop_en(stop_en), .stop_code(stop_code),
        .powerup_req(powerup_req)
    );

    always @(negedge clk) begin
        if (cyc_valid) begin n_valid++; seen_type = cyc_type; end
        if (data_valid) begin n_data++; seen_data = data; end
        if (illegal) n_ill++;
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] exp_type(bit cbr, bit trg, bit we, bit dr, bit dc);
        if (cbr) return we ? (dr ? 4'(CYC_REF_KEEP) : 4'(CYC_REF_RESET))
                           : (dr ? 4'(CYC_REF_STOP) : 4'(CYC_RSVD));
        if (!trg) return !we ? 4'(CYC_RSVD) : (dr ? 4'(CYC_XFER_SPLIT) : 4'(CYC_XFER_FULL));
        if (we && !dr) return dc ? 4'(CYC_BLOCK_WRITE) : 4'(CYC_WRITE);
        if (we && dr)  return dc ? 4'(CYC_LOAD_COLOR) : 4'(CYC_LOAD_MASK);
        return dc ? 4'(CYC_BLOCK_MASKED) : 4'(CYC_WRITE_MASKED);
    endfunction

    task automatic run_cycle(int i, bit cbr, bit trg, bit we, bit dr, bit dc);
        logic [8:0]  row = 9'(i * 37 + 5);
        logic [8:0]  col = 9'(i * 11 + 3);
        logic [15:0] dqr = 16'(i * 16'h1357) ^ 16'hA5A5;
        logic [15:0] dqd = 16'(i * 16'h0F1D) + 16'h3C3C;
        logic [3:0]  et = exp_type(cbr, trg, we, dr, dc);
        bit          late = !cbr && trg;
        bit          use_l = i[0];
        n_valid = 0; n_data = 0; n_ill = 0;
        addr = row; dq = dqr; trg_n = trg; we_n = we; dsf = dr;
        if (cbr) begin if (use_l) casl_n = 1'b0; else casu_n = 1'b0; end
        wait_clk(4);
        ras_n = 1'b0;
        wait_clk(4);
        if (late) begin
            addr = col; dsf = dc;
            dq = we ? ~dqd : dqd;
            if (use_l) casl_n = 1'b0; else casu_n = 1'b0;
            wait_clk(4);
            if (we) begin dq = dqd; we_n = 1'b0; wait_clk(4); end
        end
        ras_n = 1'b1; casl_n = 1'b1; casu_n = 1'b1; we_n = 1'b1; trg_n = 1'b1; dsf = 1'b0;
        wait_clk(6);
        // expected mask computed from the model state before this cycle
        check(n_valid == 1, "R4", "cyc_valid pulses", n_valid, 1);
        check(seen_type == et, (cbr ? "R2" : (!trg ? "R3" : "R4")), "cyc_type", seen_type, et);
        check(n_ill == (et == 4'(CYC_RSVD) ? 1 : 0), "R11", "illegal pulses", n_ill,
              (et == 4'(CYC_RSVD) ? 1 : 0));
        check(row_addr == row, "R9", "row_addr", row_addr, row);
        if (late) begin
            check(col_addr == col, "R9", "col_addr", col_addr, col);
            check(n_data == 1, "R8", "data_valid pulses", n_data, 1);
            check(seen_data == dqd, "R8", "captured data", seen_data, dqd);
            if (et == 4'(CYC_WRITE) || et == 4'(CYC_BLOCK_WRITE))
                check(wr_mask == 16'hFFFF, "R10", "unmasked wr_mask", wr_mask, 16'hFFFF);
            if (et == 4'(CYC_WRITE_MASKED) || et == 4'(CYC_BLOCK_MASKED))
                check(wr_mask == ((m_persist || dr) ? m_mask : dqr), "R10", "masked wr_mask",
                      wr_mask, ((m_persist || dr) ? m_mask : dqr));
        end else begin
            check(n_data == 0, "R8", "no data_valid", n_data, 0);
        end
        unique case (et)
            4'(CYC_REF_STOP):  begin m_stop = 1; m_code = row[7:4]; m_pwr = 0; end
            4'(CYC_REF_RESET): begin m_stop = 0; m_persist = 0; end
            4'(CYC_LOAD_MASK): begin m_persist = 1; m_mask = dqd; end
            4'(CYC_LOAD_COLOR): m_color = dqd;
            default: ;
        endcase
        check(persist_wpb == m_persist, "R5", "persist_wpb", persist_wpb, m_persist);
        check(stop_en == m_stop, "R6", "stop_en", stop_en, m_stop);
        check(stop_code == m_code, "R7", "stop_code", stop_code, m_code);
        check(powerup_req == m_pwr, "R7", "powerup_req", powerup_req, m_pwr);
        check(mask_reg == m_mask, "R5", "mask_reg", mask_reg, m_mask);
        check(color == m_color, "R5", "color", color, m_color);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        m_persist = 0; m_stop = 0; m_pwr = 1; m_code = '0; m_mask = '0; m_color = '0;
        check(persist_wpb == 0, "R1", "persist_wpb after reset", persist_wpb, 0);
        check(stop_en == 0, "R1", "stop_en after reset", stop_en, 0);
        check(powerup_req == 1, "R1", "powerup_req after reset", powerup_req, 1);
        check(cyc_valid == 0 && data_valid == 0 && illegal == 0, "R1", "pulses after reset",
              {cyc_valid, data_valid, illegal}, 0);
    endtask

    initial begin
        do_reset();
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 32; k++) begin
                int idx = pass * 32 + k;
                run_cycle(idx, k[4], k[3], k[2], k[1], k[0]);
            end
        end
        // R7: stop code ignores address bits outside 7..4
        run_cycle(7, 1, 1, 0, 1, 0);
        do_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule